// File: doc/BRIEF.md
# Leaky Integrate-and-Fire Neuron

This block models a single spiking neuron with unsigned integer arithmetic. On every clock it can take in an input spike and add a programmable weight to its membrane potential. It then takes away a leak constant, and it compares the result with a firing threshold. When the potential rises strictly above the threshold, the neuron emits a one-cycle output spike and sets its potential back to zero. It then stays refractory for a programmable number of cycles. While refractory it ignores its input and cannot fire.

The leak never takes the potential below zero, because it removes the smaller of the leak constant and the current potential. Integration stops at the largest value the potential can hold and does not wrap. The potential, the spike and the remaining refractory count are all registered outputs. This lets the block be chained to another neuron, or watched directly.

Top module: `lif_neuron`

## Requirements
- R1: Reset is synchronous and active low. After a clock edge with `rst_n` low, `membrane` is 0, `spike_out` is 0 and `refr_left` is 0.
- R2: When the neuron is not refractory and `spike_in` is high, `weight` is added to the potential. When `spike_in` is low, nothing is added.
- R3: The addition saturates at 0xFFFF and does not wrap.
- R4: Each non-refractory cycle, the sum is reduced by min(`leak`, sum), so the potential never goes below 0.
- R5: The neuron fires only when the value after the leak is strictly greater than `threshold`. A value equal to the threshold does not fire, and with `threshold` = 0xFFFF it never fires.
- R6: On firing, `spike_out` is high for exactly that one registered cycle, `membrane` becomes 0 and `refr_left` loads the `refr_len` value presented in the firing cycle.
- R7: While `refr_left` is nonzero, `spike_out` stays 0 and `spike_in` is ignored. The potential holds, and `refr_left` drops by one per cycle until it reaches 0.
- R8: With `refr_len` = 0, the neuron can integrate on the cycle after a spike and fire again.
- R9: Within one cycle the order is integrate, then leak, then compare. A spike whose weight exceeds the threshold by less than the leak does not fire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| spike_in | input | 1 | Input spike |
| weight | input | 16 | Synaptic weight added per input spike |
| threshold | input | 16 | Firing threshold, compared strictly |
| leak | input | 16 | Leak constant removed each cycle |
| refr_len | input | 8 | Refractory length loaded on firing |
| membrane | output | 16 | Membrane potential |
| spike_out | output | 1 | One-cycle output spike |
| refr_left | output | 8 | Remaining refractory cycles |

## Verification
The hardest state to reach is a potential that is pinned at 0xFFFF with input spikes still arriving. At that point only saturation keeps the value from wrapping. The stimulus reaches it with a full-scale weight, no leak and an unreachable threshold, and then lowers the threshold by one to show that firing resumes. A second hard case is an input spike during the refractory window. The bench fires the neuron with a long refractory length and then holds a large weight on the input throughout the countdown.

// File: rtl/lif_pkg.sv
package lif_pkg;

    localparam int POT_W = 16;
    localparam int REF_W = 8;

    typedef logic [POT_W-1:0] pot_t;
    typedef logic [REF_W-1:0] ref_t;

    localparam pot_t POT_MAX = {POT_W{1'b1}};

    typedef struct packed {
        pot_t potential;
        logic fire;
    } step_t;

    function automatic pot_t sat_add(input pot_t a, input pot_t b);
        logic [POT_W:0] wide;
        wide = {1'b0, a} + {1'b0, b};
        return wide[POT_W] ? POT_MAX : wide[POT_W-1:0];
    endfunction

    function automatic pot_t floor_sub(input pot_t a, input pot_t b);
        pot_t take;
        take = (b < a) ? b : a;
        return a - take;
    endfunction

endpackage

// File: rtl/lif_integrate.sv
module lif_integrate
    import lif_pkg::*;
(
    input  pot_t  pot_in,
    input  logic  spike_in,
    input  pot_t  weight,
    input  pot_t  leak,
    input  pot_t  threshold,
    output step_t result
);
    pot_t summed;
    pot_t leaked;

    always_comb begin
        summed = sat_add(pot_in, spike_in ? weight : '0);
        leaked = floor_sub(summed, leak);
        result.fire      = (leaked > threshold);
        result.potential = result.fire ? '0 : leaked;
    end

    always_comb begin
        if (!$isunknown(summed)) begin
            a_sum_ge_in_r3: assert (summed >= pot_in)
                else $error("sum fell below input potential");
            a_leak_le_sum_r4: assert (leaked <= summed)
                else $error("leak raised potential");
        end
    end
endmodule

// File: rtl/lif_refractory.sv
module lif_refractory
    import lif_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  ref_t load_val,
    output ref_t count,
    output logic busy
);
    ref_t count_q;

    assign busy  = (count_q != '0);
    assign count = count_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            count_q <= '0;
        else if (busy)
            count_q <= count_q - 1'b1;
        else if (fire)
            count_q <= load_val;
    end

    p_count_dec_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (count_q == $past(count_q) - 1'b1));
endmodule

// File: rtl/lif_neuron.sv
module lif_neuron
    import lif_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        spike_in,
    input  logic [15:0] weight,
    input  logic [15:0] threshold,
    input  logic [15:0] leak,
    input  logic [7:0]  refr_len,
    output logic [15:0] membrane,
    output logic        spike_out,
    output logic [7:0]  refr_left
);
    pot_t  pot_q;
    logic  spike_q;
    step_t nxt;
    logic  busy;
    ref_t  cnt;

    lif_integrate u_integrate (
        .pot_in    (pot_q),
        .spike_in  (spike_in),
        .weight    (weight),
        .leak      (leak),
        .threshold (threshold),
        .result    (nxt)
    );

    lif_refractory u_refractory (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (nxt.fire),
        .load_val (refr_len),
        .count    (cnt),
        .busy     (busy)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pot_q   <= '0;
            spike_q <= 1'b0;
        end else if (busy) begin
            spike_q <= 1'b0;
        end else begin
            pot_q   <= nxt.potential;
            spike_q <= nxt.fire;
        end
    end

    assign membrane  = pot_q;
    assign spike_out = spike_q;
    assign refr_left = cnt;

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (pot_q == '0 && !spike_q && cnt == '0));
    p_no_spike_refr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !spike_q);
    p_hold_refr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(pot_q));
    p_fire_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        spike_q |-> (pot_q == '0));
    p_fire_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && nxt.fire) |=> (spike_q && cnt == $past(refr_len)));
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && spike_in && pot_q == POT_MAX && leak == '0 && threshold == POT_MAX)
        |=> (pot_q == POT_MAX));
    p_leak_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !spike_in) |=> (pot_q <= $past(pot_q)));
endmodule

// File: tb/lif_neuron_bench.sv
`timescale 1ns/1ps
module lif_neuron_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        spike_in;
    logic [15:0] weight, threshold, leak;
    logic [7:0]  refr_len;
    logic [15:0] membrane;
    logic        spike_out;
    logic [7:0]  refr_left;

    int n_tests = 0;
    int n_fail  = 0;
    logic done = 1'b0;

    // reference state built from the requirements
    int m_v, m_c, m_s;

    always #4 clk = ~clk;

    lif_neuron u_lif_neuron (
        .clk(clk), .rst_n(rst_n), .spike_in(spike_in), .weight(weight),
        .threshold(threshold), .leak(leak), .refr_len(refr_len),
        .membrane(membrane), .spike_out(spike_out), .refr_left(refr_left)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // one cycle: drive at negedge, predict, sample at next negedge
    task automatic step(input logic spk, input string req);
        int s;
        spike_in = spk;
        if (!rst_n) begin
            m_v = 0; m_c = 0; m_s = 0;
        end else if (m_c != 0) begin
            m_c = m_c - 1; m_s = 0;
        end else begin
            s = m_v + (spk ? int'(weight) : 0);
            if (s > 65535) s = 65535;                 // R3
            s = s - ((int'(leak) < s) ? int'(leak) : s); // R4
            if (s > int'(threshold)) begin            // R5, R6
                m_s = 1; m_v = 0; m_c = int'(refr_len);
            end else begin
                m_s = 0; m_v = s;
            end
        end
        @(posedge clk);
        @(negedge clk);
        check({req, " membrane"}, int'(membrane), m_v);
        check({req, " spike"}, int'(spike_out), m_s);
        check({req, " refr"}, int'(refr_left), m_c);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step(1'b1, "R1");
        step(1'b0, "R1");
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        weight = 16'd9; threshold = 16'd3; leak = 16'd0; refr_len = 8'd4;
        do_reset();
        check("R1 membrane zero", int'(membrane), 0);
        check("R1 refr zero", int'(refr_left), 0);
    endtask

    task automatic t_integrate_leak();
        weight = 16'd10; threshold = 16'd100; leak = 16'd3; refr_len = 8'd2;
        do_reset();
        step(1'b1, "R2");               // 10-3 = 7
        check("R2 after one spike", int'(membrane), 7);
        step(1'b1, "R2");               // 14
        step(1'b0, "R2 no spike");      // 11
        check("R2 idle leaks only", int'(membrane), 11);
        leak = 16'd50;
        step(1'b0, "R4 floor");
        check("R4 floor at zero", int'(membrane), 0);
        step(1'b0, "R4 stays zero");
    endtask

    task automatic t_threshold_equal();
        weight = 16'd5; threshold = 16'd5; leak = 16'd0; refr_len = 8'd1;
        do_reset();
        step(1'b1, "R5 equal");
        check("R5 equal does not fire", int'(spike_out), 0);
        step(1'b1, "R5 above");
        check("R5 above fires", int'(spike_out), 1);
        check("R6 membrane cleared", int'(membrane), 0);
        check("R6 refr loaded", int'(refr_left), 1);
        step(1'b0, "R6 one-cycle pulse");
        check("R6 pulse ends", int'(spike_out), 0);
    endtask

    task automatic t_refractory_ignore();
        weight = 16'd20; threshold = 16'd10; leak = 16'd1; refr_len = 8'd5;
        do_reset();
        step(1'b1, "R6 fire");
        check("R6 fired", int'(spike_out), 1);
        weight = 16'd60000;
        for (int i = 0; i < 5; i++) step(1'b1, "R7 ignored");
        check("R7 potential held at zero", int'(membrane), 0);
        check("R7 counter done", int'(refr_left), 0);
        weight = 16'd4;
        step(1'b1, "R7 resumes");
        check("R7 integrates after window", int'(membrane), 3);
    endtask

    task automatic t_back_to_back();
        weight = 16'd9; threshold = 16'd4; leak = 16'd1; refr_len = 8'd0;
        do_reset();
        step(1'b1, "R8 first");
        step(1'b1, "R8 second");
        check("R8 fires again next cycle", int'(spike_out), 1);
        check("R8 no refractory", int'(refr_left), 0);
    endtask

    task automatic t_order();
        weight = 16'd12; threshold = 16'd10; leak = 16'd3; refr_len = 8'd0;
        do_reset();
        step(1'b1, "R9 leak before compare");
        check("R9 12-3 not above 10", int'(spike_out), 0);
        check("R9 potential 9", int'(membrane), 9);
    endtask

    task automatic t_saturate();
        weight = 16'hFFFF; threshold = 16'hFFFF; leak = 16'd0; refr_len = 8'd3;
        do_reset();
        step(1'b1, "R3 fill");
        step(1'b1, "R3 pinned");
        step(1'b1, "R3 pinned");
        check("R3 no wrap", int'(membrane), 65535);
        check("R5 max threshold never fires", int'(spike_out), 0);
        threshold = 16'hFFFE;
        step(1'b1, "R5 fires at max");
        check("R5 fires above FFFE", int'(spike_out), 1);
    endtask

    initial begin
        rst_n = 1'b0; spike_in = 1'b0;
        weight = '0; threshold = '0; leak = '0; refr_len = '0;
        m_v = 0; m_c = 0; m_s = 0;
        @(negedge clk);
        t_reset_state();
        t_integrate_leak();
        t_threshold_equal();
        t_refractory_ignore();
        t_back_to_back();
        t_order();
        t_saturate();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule